// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the register file that a host CPU sees for a four-channel DMA controller. Every register sits behind a 4-bit port offset on an 8-bit data bus. Each channel's 16-bit address and 16-bit count are moved a byte at a time. One shared byte pointer decides whether an access goes to the low byte or the high byte, and the pointer flips after each access. The block also keeps a command byte, a per-channel mode, a software request per channel, a terminal-count status nibble and a four-bit channel mask. It decodes the control writes that set or clear those bits.

The transfer engine sits beside this block. The engine reads the base and current register values and the mask from flat output vectors. The engine writes the progress of a channel back through a small update port, and it reports when a channel reaches terminal count. A host read therefore returns the live current address or count. A count register holds the number of transfers minus one. After a channel finishes, its count reads back as 0xFFFF.

Top module: `dma_regfile`

## Requirements
- R1: After reset the mask is 4'hF, the command and request registers are zero, the status reads 0x00, all address and count registers are zero, and the byte pointer selects the low byte.
- R2: A write to an address or count port updates the byte chosen by the pointer, low byte first, in both the base and the current copy. A read of the same port returns the current copy, low byte first.
- R3: Every read or write of ports 0x0 to 0x7 flips the byte pointer once. A write to port 0xC returns the pointer to the low byte whatever the data.
- R4: Channel n's address register sits at port 2n and its count register at port 2n+1.
- R5: A write to port 0xA uses data[1:0] to pick a channel. It masks that channel when data[2] is 1 and unmasks it when data[2] is 0. Mask bit n is mask_o[n].
- R6: A write to port 0xE clears all four mask bits. A write to port 0xF loads the mask from data[3:0].
- R7: A write to port 0xD (master clear) zeroes the command, request and status and resets the pointer to low. It sets all mask bits. Address, count and mode registers keep their values.
- R8: A write to port 0xB stores data[7:2] as the mode of the channel picked by data[1:0]. Channel n's mode is mode_o[6n+5:6n]. For example, 0x44 stores 6'h11, 0x48 stores 6'h12 and 0xC0 stores 6'h30.
- R9: A write to port 0x8 loads the command byte. A write to port 0x9 sets the request bit of channel data[1:0] when data[2] is 1 and clears it when data[2] is 0.
- R10: An engine update loads the current address and current count of channel eng_ch and leaves the base copies unchanged. Host reads then return the new current values.
- R11: An eng_tc pulse sets status bit eng_ch. A read of port 0x8 returns {req[3:0], tc[3:0]} and then clears the tc bits. If a tc pulse arrives in the same cycle as that read, its bit survives the clear.
- R12: If a host write hits a channel register in the same cycle as an engine update of that register, the host byte is applied and the engine value is dropped for that register. The engine value still applies to the channel's other register.
- R13: Reads of port 0xD and of ports 0x9 to 0xF return 0x00 and do not move the byte pointer. io_rd is ignored while io_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one per clock |
| io_rd | input | 1 | Read strobe, one per clock |
| io_rdata | output | 8 | Read data (combinational) |
| eng_we | input | 1 | Engine update of current address and count |
| eng_ch | input | 2 | Channel for engine update and tc |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_tc | input | 1 | Terminal count reached on eng_ch |
| mask_o | output | 4 | Channel mask bits |
| cmd_o | output | 8 | Command register |
| req_o | output | 4 | Software request bits |
| mode_o | output | 24 | Per-channel 6-bit modes |
| base_addr_o | output | 64 | Base addresses, channel n at [16n+15:16n] |
| base_cnt_o | output | 64 | Base counts |
| cur_addr_o | output | 64 | Current addresses |
| cur_cnt_o | output | 64 | Current counts |

## Verification
Two pairs of functions can fall in the same cycle. The first is a status read, which clears tc, arriving together with an engine tc pulse. The second is a host byte write arriving together with an engine update of the same channel. The bench provokes each pair by driving both stimuli in one cycle. It judges the status pair by two reads: the colliding read must show the old status, and the next read must show the new tc bit. It judges the write pair by the current address and count vectors, where the host byte must win one register while the engine value lands in the other. A behavioural model in the bench also checks all register outputs every clock.

// File: rtl/dma_regfile.sv
module dma_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic        eng_we,
  input  logic [1:0]  eng_ch,
  input  logic [15:0] eng_addr,
  input  logic [15:0] eng_cnt,
  input  logic        eng_tc,
  output logic [3:0]  mask_o,
  output logic [7:0]  cmd_o,
  output logic [3:0]  req_o,
  output logic [23:0] mode_o,
  output logic [63:0] base_addr_o,
  output logic [63:0] base_cnt_o,
  output logic [63:0] cur_addr_o,
  output logic [63:0] cur_cnt_o
);
  localparam int NCH = 4;

  logic       ff;
  logic [3:0] mask, req, tc;
  logic [7:0] cmd;

  wire       rd      = io_rd & ~io_wr;
  wire       chan    = ~io_addr[3];
  wire [1:0] pch     = io_addr[2:1];
  wire       acc     = chan & (io_wr | rd);
  wire       w_cmd   = io_wr && io_addr == 4'h8;
  wire       w_req   = io_wr && io_addr == 4'h9;
  wire       w_smask = io_wr && io_addr == 4'hA;
  wire       w_mode  = io_wr && io_addr == 4'hB;
  wire       w_clrff = io_wr && io_addr == 4'hC;
  wire       w_mclr  = io_wr && io_addr == 4'hD;
  wire       w_clrm  = io_wr && io_addr == 4'hE;
  wire       w_mall  = io_wr && io_addr == 4'hF;
  wire       st_rd   = rd && io_addr == 4'h8;
  wire [3:0] tc_set  = eng_tc ? (4'b0001 << eng_ch) : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n)                ff <= 1'b0;
    else if (w_mclr | w_clrff) ff <= 1'b0;
    else if (acc)              ff <= ~ff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= 4'hF;
      req  <= 4'h0;
      tc   <= 4'h0;
      cmd  <= 8'h00;
    end else if (w_mclr) begin
      mask <= 4'hF;
      req  <= 4'h0;
      tc   <= 4'h0;
      cmd  <= 8'h00;
    end else begin
      tc <= (st_rd ? 4'h0 : tc) | tc_set;
      if (w_cmd) cmd <= io_wdata;
      if (w_req) req[io_wdata[1:0]] <= io_wdata[2];
      if (w_smask) mask[io_wdata[1:0]] <= io_wdata[2];
      else if (w_clrm) mask <= 4'h0;
      else if (w_mall) mask <= io_wdata[3:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [15:0] ba, ca, bc, cc;
    logic [5:0]  md;
    wire hw   = io_wr && chan && pch == 2'(i);
    wire hw_a = hw && !io_addr[0];
    wire hw_c = hw &&  io_addr[0];
    wire ew   = eng_we && eng_ch == 2'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ba <= '0; ca <= '0; bc <= '0; cc <= '0; md <= '0;
      end else begin
        if (hw_a) begin
          if (ff) begin ba[15:8] <= io_wdata; ca[15:8] <= io_wdata; end
          else    begin ba[7:0]  <= io_wdata; ca[7:0]  <= io_wdata; end
        end else if (ew) ca <= eng_addr;
        if (hw_c) begin
          if (ff) begin bc[15:8] <= io_wdata; cc[15:8] <= io_wdata; end
          else    begin bc[7:0]  <= io_wdata; cc[7:0]  <= io_wdata; end
        end else if (ew) cc <= eng_cnt;
        if (w_mode && io_wdata[1:0] == 2'(i)) md <= io_wdata[7:2];
      end
    end

    assign base_addr_o[16*i +: 16] = ba;
    assign cur_addr_o[16*i +: 16]  = ca;
    assign base_cnt_o[16*i +: 16]  = bc;
    assign cur_cnt_o[16*i +: 16]   = cc;
    assign mode_o[6*i +: 6]        = md;
  end

  wire [15:0] sel = io_addr[0] ? cur_cnt_o[{pch, 4'b0000} +: 16]
                               : cur_addr_o[{pch, 4'b0000} +: 16];

  assign io_rdata = chan ? (ff ? sel[15:8] : sel[7:0])
                  : (io_addr == 4'h8) ? {req, tc} : 8'h00;
  assign mask_o = mask;
  assign cmd_o  = cmd;
  assign req_o  = req;

  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ff != $past(ff));
  a_r3_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    w_clrff |=> !ff);
  a_r7_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    w_mclr |=> mask_o == 4'hF && cmd_o == 8'h00 && req_o == 4'h0 && tc == 4'h0 && !ff);
  a_r6_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    w_clrm |=> mask_o == 4'h0);
  a_r11_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tc && !w_mclr) |=> tc[$past(eng_ch)]);
  a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(base_addr_o) && $stable(base_cnt_o));
  a_r13_no_ptr_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !(io_rd && chan)) |=> $stable(ff));
endmodule

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0, eng_we = 0, eng_tc = 0;
  logic [1:0] eng_ch = 0;
  logic [15:0] eng_addr = 0, eng_cnt = 0;
  logic [3:0] mask_o, req_o;
  logic [7:0] cmd_o;
  logic [23:0] mode_o;
  logic [63:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;

  always #2.5 clk = ~clk;

  dma_regfile uut (.*);

  int nchk = 0, nerr = 0, last_rd = 0;
  int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_mode[4];
  int m_mask, m_req, m_tc, m_cmd, ntc, a, d, ch;
  bit m_ff, w, r, hwa, hwc;

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int setb(int v, bit hi, int b);
    return hi ? ((v & 'h00FF) | (b << 8)) : ((v & 'hFF00) | b);
  endfunction

  function automatic int exp_rd(int ad);
    int v;
    if (ad < 8) begin
      v = (ad % 2) ? m_cc[ad/2] : m_ca[ad/2];
      return m_ff ? (v >> 8) & 255 : v & 255;
    end
    if (ad == 8) return (m_req << 4) | m_tc;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 15; m_req = 0; m_tc = 0; m_cmd = 0; m_ff = 0;
    end else begin
      w = io_wr; r = io_rd && !io_wr; a = io_addr; d = io_wdata;
      ch = (a >> 1) & 3; hwa = 0; hwc = 0; ntc = m_tc;
      if (r && a == 8) ntc = 0;
      if (eng_tc) ntc = ntc | (1 << eng_ch);
      if (w && a < 8) begin
        if (a % 2 == 0) begin
          hwa = 1; m_ba[ch] = setb(m_ba[ch], m_ff, d); m_ca[ch] = setb(m_ca[ch], m_ff, d);
        end else begin
          hwc = 1; m_bc[ch] = setb(m_bc[ch], m_ff, d); m_cc[ch] = setb(m_cc[ch], m_ff, d);
        end
      end
      if (eng_we) begin
        if (!(hwa && ch == eng_ch)) m_ca[eng_ch] = eng_addr;
        if (!(hwc && ch == eng_ch)) m_cc[eng_ch] = eng_cnt;
      end
      if (a < 8 && (w || r)) m_ff = !m_ff;
      if (w) case (a)
        8:  m_cmd = d;
        9:  m_req = d[2] ? (m_req | (1 << (d & 3))) : (m_req & ~(1 << (d & 3)));
        10: m_mask = d[2] ? (m_mask | (1 << (d & 3))) : (m_mask & ~(1 << (d & 3)));
        11: m_mode[d & 3] = d >> 2;
        12: m_ff = 0;
        13: begin m_cmd = 0; m_req = 0; ntc = 0; m_mask = 15; m_ff = 0; end
        14: m_mask = 0;
        15: m_mask = d & 15;
        default: ;
      endcase
      m_tc = ntc;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R5 mask", mask_o, m_mask);
    check("R9 cmd", cmd_o, m_cmd);
    check("R9 req", req_o, m_req);
    for (int i = 0; i < 4; i++) begin
      check("R8 mode", mode_o[6*i +: 6], m_mode[i]);
      check("R2 base addr", base_addr_o[16*i +: 16], m_ba[i]);
      check("R2 base cnt", base_cnt_o[16*i +: 16], m_bc[i]);
      check("R10 cur addr", cur_addr_o[16*i +: 16], m_ca[i]);
      check("R10 cur cnt", cur_cnt_o[16*i +: 16], m_cc[i]);
    end
  end

  task automatic cyc(bit cw, bit cr, int ca, int cd, bit ewe, int ech, int ea, int ec, bit etc);
    @(negedge clk); #1;
    io_wr = cw; io_rd = cr; io_addr = 4'(ca); io_wdata = 8'(cd);
    eng_we = ewe; eng_ch = 2'(ech); eng_addr = 16'(ea); eng_cnt = 16'(ec); eng_tc = etc;
    #1;
    last_rd = io_rdata;
    if (cr && !cw) check("R4 read model", last_rd, exp_rd(ca));
  endtask

  task automatic wr(int ca, int cd); cyc(1, 0, ca, cd, 0, 0, 0, 0, 0); endtask
  task automatic rd(int ca);         cyc(0, 1, ca, 0, 0, 0, 0, 0, 0); endtask
  task automatic idle();             cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle();
    check("R1 mask", mask_o, 'hF); check("R1 cmd", cmd_o, 0); check("R1 req", req_o, 0);
    rd(8); check("R1 status", last_rd, 0);
    rd(1); check("R1 cnt lo", last_rd, 0);
    rd(1); check("R1 cnt hi", last_rd, 0);
    wr(2, 'h34); wr(2, 'h12); wr(3, 'hFF); wr(3, 'h00);
    rd(2); check("R2 addr lo", last_rd, 'h34);
    rd(2); check("R2 addr hi", last_rd, 'h12);
    rd(3); check("R2 cnt lo", last_rd, 'hFF);
    rd(3); check("R2 cnt hi", last_rd, 'h00);
    check("R2 base", base_addr_o[31:16], 'h1234);
    wr(4, 'h99); wr(12, 'hA5); wr(4, 'h78); wr(4, 'h56);
    rd(4); check("R3 after clear lo", last_rd, 'h78);
    rd(4); check("R3 after clear hi", last_rd, 'h56);
    rd(2); check("R3 read toggles", last_rd, 'h34);
    wr(7, 'hAB); wr(12, 0);
    rd(7); check("R3 lo", last_rd, 'h00);
    rd(7); check("R3 hi", last_rd, 'hAB);
    wr(6, 'h11); wr(6, 'h22); idle();
    check("R4 ch3 addr", cur_addr_o[63:48], 'h2211);
    check("R4 ch3 cnt", cur_cnt_o[63:48], 'hAB00);
    wr(10, 'h00); wr(10, 'h02); idle(); check("R5 unmask", mask_o, 'hA);
    wr(10, 'h06); idle(); check("R5 mask", mask_o, 'hE);
    wr(14, 0); idle(); check("R6 clear", mask_o, 0);
    wr(15, 'hF5); idle(); check("R6 load", mask_o, 5);
    wr(11, 'h45); wr(11, 'h4A); wr(11, 'hC3); idle();
    check("R8 ch1", mode_o[11:6], 'h11);
    check("R8 ch2", mode_o[17:12], 'h12);
    check("R8 ch3", mode_o[23:18], 'h30);
    wr(8, 'h24); wr(9, 'h05); wr(9, 'h04); wr(9, 'h01); idle();
    check("R9 cmd", cmd_o, 'h24); check("R9 req", req_o, 1);
    cyc(0, 0, 0, 0, 1, 1, 'h1300, 'hFFFF, 0);
    rd(3); check("R10 cnt lo", last_rd, 'hFF);
    rd(3); check("R10 cnt hi", last_rd, 'hFF);
    check("R10 base", base_cnt_o[31:16], 'h00FF);
    check("R10 cur", cur_addr_o[31:16], 'h1300);
    cyc(0, 0, 0, 0, 0, 2, 0, 0, 1);
    rd(8); check("R11 tc", last_rd, 'h14);
    rd(8); check("R11 cleared", last_rd, 'h10);
    cyc(0, 1, 8, 0, 0, 3, 0, 0, 1); check("R11 collide read", last_rd, 'h10);
    rd(8); check("R11 survives", last_rd, 'h18);
    rd(8); check("R11 clear again", last_rd, 'h10);
    cyc(1, 0, 0, 'hCD, 1, 0, 'hBEEF, 'h0777, 0); idle();
    check("R12 host wins", cur_addr_o[15:0], 'h00CD);
    check("R12 engine other", cur_cnt_o[15:0], 'h0777);
    wr(12, 0);
    rd(13); check("R13 temp", last_rd, 0);
    rd(12); check("R13 unmapped", last_rd, 0);
    rd(0); check("R13 ptr kept", last_rd, 'hCD);
    rd(0); check("R13 hi", last_rd, 'h00);
    wr(0, 'h11); wr(13, 0); idle();
    check("R7 mask", mask_o, 'hF); check("R7 cmd", cmd_o, 0); check("R7 req", req_o, 0);
    check("R7 addr kept", cur_addr_o[31:16], 'h1300);
    check("R7 mode kept", mode_o[23:18], 'h30);
    rd(8); check("R7 status", last_rd, 0);
    rd(0); check("R7 ptr low", last_rd, 'h11);
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nchk++; nerr++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule